// File: doc/BRIEF.md
# MDIO Management Access Engine

This block lets host software reach the management registers of an external Ethernet PHY. Software uses two registers. The command register holds the target PHY address, the register index, a direction bit and a start/busy flag. The data register holds 16 bits of payload. When software sets the busy flag while the engine is idle, the engine runs one clause-22 management frame on the MDC/MDIO pins. It clears the flag itself when the frame ends.

For a write, the engine shifts out the contents of the data register. For a read, it releases the data line during turnaround. It then samples the 16 bits the PHY returns and places them in the data register in the same cycle that busy drops.

MDC is derived from the system clock. Each MDC phase lasts `ceil(CLK_HZ / (2*MDC_HZ))` system cycles. While idle, MDC is held low and the data line is released.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: Command register bits 31:16 and 5:2 always read as 0, whatever value was written to them.
- R2: After reset the command register reads 0 and the data register reads 0. The PHY address (bits 15:11), register index (bits 10:6) and direction (bit 1, 1 = write) read back as last written.
- R3: A command write made while idle with bit 0 = 1 starts a frame. Busy (bit 0) then reads 1 for exactly 128 MDC phases (64 MDC periods) and clears by itself.
- R4: A command write made while busy is 1 has no effect on any field or on the frame in progress.
- R5: The frame is sent MSB first as follows: 32 ones, then 01, then the opcode (01 for write, 10 for read), then the 5-bit PHY address, then the 5-bit register index, then the turnaround, then 16 data bits. A write uses turnaround 10 and sends the data register's contents.
- R6: On a read, MDIO output enable is low for the two turnaround bits and the 16 data bits. The 16 bits sampled from mdio_i appear in the data register in the cycle busy clears, and not earlier.
- R7: Data register writes take effect only while idle. Writes made while busy are ignored, so the register stays stable for the whole frame.
- R8: MDC has phases of `ceil(CLK_HZ/(2*MDC_HZ))` system cycles, starting low. MDIO and its enable change only at MDC falling edges, and mdio_i is sampled at MDC rising edges.
- R9: While idle, MDC is 0 and mdio_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command register write value |
| cmd_rdata | output | 32 | Command register read value |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 16 | Data register write value |
| dat_rdata | output | 16 | Data register read value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable (0 = released) |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
The assertions check several properties on every cycle:
- the reserved command bits stay zero;
- the line is released and MDC is low while idle;
- the fields and the data register hold steady while busy;
- MDIO never moves while MDC is high.

The bench's scenarios, compared against a cycle-counting model, are needed to show the rest: the exact bit order of write and read frames, the busy length, the captured read word, and that writes arriving mid-frame are dropped.

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine #(
  parameter int CLK_HZ = 250_000_000,
  parameter int MDC_HZ = 2_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  input  logic        dat_we,
  input  logic [15:0] dat_wdata,
  output logic [15:0] dat_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF = (CLK_HZ + 2 * MDC_HZ - 1) / (2 * MDC_HZ);
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic        busy, wr;
  logic [4:0]  phy, rix;
  logic [15:0] dat, rd_sh;
  logic [DW-1:0] div;
  logic [5:0]  bitn;
  logic [63:0] frame;

  wire tick = (div == DW'(HALF - 1));
  wire rise = busy && tick && !mdc;
  wire fall = busy && tick && mdc;

  assign frame = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rix,
                  wr ? 2'b10 : 2'b00, wr ? dat : 16'h0000};
  assign mdio_o    = busy ? frame[6'd63 - bitn] : 1'b1;
  assign mdio_oe   = busy && (wr || bitn < 6'd46);
  assign cmd_rdata = {16'h0000, phy, rix, 4'h0, wr, busy};
  assign dat_rdata = dat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      wr    <= 1'b0;
      phy   <= '0;
      rix   <= '0;
      dat   <= '0;
      rd_sh <= '0;
      div   <= '0;
      mdc   <= 1'b0;
      bitn  <= '0;
    end else if (!busy) begin
      div  <= '0;
      mdc  <= 1'b0;
      bitn <= '0;
      if (dat_we) dat <= dat_wdata;
      if (cmd_we) begin
        phy  <= cmd_wdata[15:11];
        rix  <= cmd_wdata[10:6];
        wr   <= cmd_wdata[1];
        busy <= cmd_wdata[0];
      end
    end else begin
      div <= tick ? '0 : div + DW'(1);
      if (tick) mdc <= ~mdc;
      if (rise && bitn >= 6'd48) rd_sh <= {rd_sh[14:0], mdio_i};
      if (fall) begin
        bitn <= bitn + 6'd1;
        if (bitn == 6'd63) begin
          busy <= 1'b0;
          if (!wr) dat <= rd_sh;
        end
      end
    end
  end
endmodule

module mdio_mgmt_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cmd_rdata,
  input logic [15:0] dat_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdata[31:16] == 16'h0 && cmd_rdata[5:2] == 4'h0);

  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rdata[0] |-> (!mdc && !mdio_oe));

  a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdata[0] && $past(cmd_rdata[0])) |-> $stable(cmd_rdata[15:1]));

  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdata[0] && $past(cmd_rdata[0])) |-> $stable(dat_rdata));

  a_r8_mdio_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_mgmt_engine mdio_mgmt_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_rdata(cmd_rdata), .dat_rdata(dat_rdata),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/test_mdio_mgmt_engine.sv
module test_mdio_mgmt_engine;
  localparam int CLK_HZ = 250_000_000;
  localparam int MDC_HZ = 2_500_000;
  localparam int HALF   = (CLK_HZ + 2 * MDC_HZ - 1) / (2 * MDC_HZ);

  logic        clk = 0, rst_n = 0, cmd_we = 0, dat_we = 0, mdio_i = 1;
  logic [31:0] cmd_wdata = '0;
  logic [15:0] dat_wdata = '0;
  wire  [31:0] cmd_rdata;
  wire  [15:0] dat_rdata;
  wire         mdc, mdio_o, mdio_oe;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mdio_mgmt_engine #(.CLK_HZ(CLK_HZ), .MDC_HZ(MDC_HZ)) i_mdio_mgmt_engine (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .dat_rdata(dat_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i));

  bit m_busy, m_wr;
  bit [4:0] m_phy, m_rix;
  bit [15:0] m_dat, phy_word;
  int t;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_phy = 0; m_rix = 0; m_dat = 0; t = 0;
    end else if (m_busy) begin
      t++;
      if (t == 128 * HALF) begin
        m_busy = 0;
        if (!m_wr) m_dat = phy_word;
      end
    end else begin
      if (dat_we) m_dat = dat_wdata;
      if (cmd_we) begin
        m_phy = cmd_wdata[15:11]; m_rix = cmd_wdata[10:6];
        m_wr = cmd_wdata[1]; m_busy = cmd_wdata[0]; t = 0;
      end
    end
  end

  function automatic bit exp_bit(int b);
    if (b < 32) return 1'b1;
    if (b == 32) return 1'b0;
    if (b == 33) return 1'b1;
    if (b == 34) return m_wr ? 1'b0 : 1'b1;
    if (b == 35) return m_wr ? 1'b1 : 1'b0;
    if (b < 41) return m_phy[40 - b];
    if (b < 46) return m_rix[45 - b];
    if (b == 46) return 1'b1;
    if (b == 47) return 1'b0;
    return m_dat[63 - b];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int b;
    b = m_busy ? t / (2 * HALF) : 0;
    mdio_i = (m_busy && !m_wr && b >= 48) ? phy_word[63 - b] : 1'b1;
    if (rst_n && !done) begin
      chk("R3", "cmd_rdata", cmd_rdata, {16'h0, m_phy, m_rix, 4'h0, m_wr, m_busy});
      chk("R7", "dat_rdata", {16'h0, dat_rdata}, {16'h0, m_dat});
      chk("R8", "mdc", {31'h0, mdc}, {31'h0, m_busy && ((t / HALF) % 2 == 1)});
      chk("R6", "mdio_oe", {31'h0, mdio_oe}, {31'h0, m_busy && (m_wr || b < 46)});
      if (m_busy && (m_wr || b < 46))
        chk("R5", "mdio_o", {31'h0, mdio_o}, {31'h0, exp_bit(b)});
    end
  end

  task automatic cmd(logic [31:0] w);
    @(negedge clk); cmd_we = 1; cmd_wdata = w;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic dwr(logic [15:0] w);
    @(negedge clk); dat_we = 1; dat_wdata = w;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] go(bit [4:0] p, bit [4:0] r, bit w);
    return {16'h0, p, r, 4'h0, w, 1'b1};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2", "reset cmd", cmd_rdata, 32'h0);
    chk("R2", "reset dat", {16'h0, dat_rdata}, 32'h0);
    chk("R9", "idle mdc/oe", {30'h0, mdc, mdio_oe}, 32'h0);

    cmd(32'hFFFF_FFFE);
    chk("R1", "reserved masked", cmd_rdata, 32'h0000_FFC2);
    dwr(16'h1234);
    chk("R7", "idle data write", {16'h0, dat_rdata}, 32'h1234);

    cmd(go(5'h03, 5'h11, 1'b1));
    repeat (1000) @(negedge clk);
    cmd(32'h0000_0000);
    chk("R4", "cmd while busy", cmd_rdata, go(5'h03, 5'h11, 1'b1) | 32'h2);
    dwr(16'hBEEF);
    chk("R7", "data while busy", {16'h0, dat_rdata}, 32'h1234);
    wait_idle();
    chk("R3", "self clear", cmd_rdata, {16'h0, 5'h03, 5'h11, 4'h0, 1'b1, 1'b0});
    chk("R7", "data after write", {16'h0, dat_rdata}, 32'h1234);

    begin
      int n;
      n = 0;
      phy_word = 16'hA5C3;
      cmd(go(5'h01, 5'h02, 1'b0));
      while (cmd_rdata[0]) begin
        if (dat_rdata !== 16'h1234) chk("R6", "early update", {16'h0, dat_rdata}, 32'h1234);
        n++;
        @(negedge clk);
      end
      chk("R3", "busy length", n, 128 * HALF);
      chk("R6", "read capture", {16'h0, dat_rdata}, 32'hA5C3);
    end

    phy_word = 16'h0001;
    cmd(go(5'h1F, 5'h00, 1'b0));
    wait_idle();
    chk("R6", "read lsb", {16'h0, dat_rdata}, 32'h0001);

    dwr(16'h8001);
    cmd(go(5'h00, 5'h1F, 1'b1));
    wait_idle();
    chk("R9", "idle after write", {30'h0, mdc, mdio_oe}, 32'h0);

    phy_word = 16'hFFFF;
    cmd(go(5'h15, 5'h0A, 1'b0));
    wait_idle();
    chk("R6", "read ones", {16'h0, dat_rdata}, 32'hFFFF);
    chk("R1", "reserved after read", cmd_rdata & 32'hFFFF_003C, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule